// File: doc/BRIEF.md
# Data Bus Address Decoder

This block connects a single processor data-memory port to several slave ports. Each slave owns a window of the address space, and parameters set where each window begins. In the same cycle that a request arrives, the block compares the request address against the window boundaries. It then passes the address, write data, byte lanes, write-enable and strobe to the one slave that owns that address. Every other slave sees an idle, all-zero request. A fast local memory, a set of peripherals and a bridge to a slower bus can therefore share one processor data port.

The request path is purely combinational, so the decoder adds no clock cycle of latency. The ready signal comes back combinationally from the slave currently addressed.

Read data returns one cycle after the read is issued. By then the processor may already be presenting a new address. For that reason, a small state machine registers the index of the port that took each read and steers the returned data from that port. The machine has two states. RET_IDLE means the previous cycle issued no read, and the returned data is held at zero. RET_READ means the previous cycle issued a read, and the returned data comes from the registered port. The same transition rule applies in both states. A read strobe takes the machine to RET_READ (transition READ_ISSUED). Any other cycle takes it to RET_IDLE (transition NO_READ).

Top module: `dbd_decoder`

## Requirements
- R1: After synchronous reset, no slave strobe is high, `m_rdata` is zero and `m_ready` is high.
- R2: Port 0 owns every address below the base of port 1. Port i owns addresses from its own base up to, but not including, the base of port i+1. The last port owns every address from its base upward. The default bases for ports 1, 2 and 3 are 0x1000_0000, 0x8000_0000 and 0xC000_0000.
- R3: In the same cycle, the addressed port receives the request address, write data and 4-bit byte-select unchanged.
- R4: While a request is strobed, exactly one port has its strobe high. Every other port sees strobe low, write-enable low, and address, write data and byte-select all zero.
- R5: When `m_stb` is low, every port sees strobe low, write-enable low and all-zero fields.
- R6: A slave's write-enable is high only on the addressed port, and only for a request with `m_we` high.
- R7: In the cycle after a read (`m_stb` high, `m_we` low), `m_rdata` equals the read data of the port that took that read. This holds whatever address the processor presents in that later cycle.
- R8: In the cycle after any cycle that issued no read (a write or no strobe), `m_rdata` is zero.
- R9: While `m_stb` is high, `m_ready` follows the ready input of the addressed port, and ready inputs of other ports have no effect. While `m_stb` is low, `m_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| m_addr | input | AW | Processor request address |
| m_wdata | input | DW | Processor write data |
| m_sel | input | DW/8 | Processor byte-lane select |
| m_we | input | 1 | Processor write-enable |
| m_stb | input | 1 | Processor request strobe |
| m_rdata | output | DW | Read data returned to processor |
| m_ready | output | 1 | Ready returned to processor |
| s_addr | output | NPORT*AW | Per-port address, port i at slice i |
| s_wdata | output | NPORT*DW | Per-port write data |
| s_sel | output | NPORT*DW/8 | Per-port byte-lane select |
| s_we | output | NPORT | Per-port write-enable |
| s_stb | output | NPORT | Per-port strobe |
| s_rdata | input | NPORT*DW | Per-port read data |
| s_ready | input | NPORT | Per-port ready |

## Verification
The bench builds the block with its default parameters: four ports, 32-bit addresses and data, and bases at 0x1000_0000, 0x8000_0000 and 0xC000_0000. With four windows, the bench can probe the lowest and highest address of every window, including the zero address and the all-ones address that the last port catches. Two reads issued back to back to different windows show that the returned data follows the registered port and not the current address. Because each port's read data is distinct, a wrong steering choice shows up in the returned value.

// File: rtl/dbd_pkg.sv
package dbd_pkg;

    typedef enum logic [0:0] {
        RET_IDLE = 1'b0,
        RET_READ = 1'b1
    } ret_state_t;

endpackage

// File: rtl/dbd_region_match.sv
module dbd_region_match #(
    parameter int          NPORT    = 4,
    parameter int          AW       = 32,
    parameter int          IW       = 2,
    parameter logic [NPORT*AW-1:0] BASE_MAP = '0
) (
    input  logic [AW-1:0]    addr,
    output logic [NPORT-1:0] hit,
    output logic [IW-1:0]    idx
);

    // at_or_above[i]: address lies at or above base of window i
    logic [NPORT-1:0] at_or_above;

    generate
        for (genvar i = 0; i < NPORT; i++) begin : g_cmp
            if (i == 0) begin : g_first
                assign at_or_above[i] = 1'b1;
            end else begin : g_rest
                assign at_or_above[i] = (addr >= BASE_MAP[i*AW +: AW]);
            end
        end

        for (genvar i = 0; i < NPORT; i++) begin : g_hit
            if (i == NPORT - 1) begin : g_top
                assign hit[i] = at_or_above[i];
            end else begin : g_mid
                assign hit[i] = at_or_above[i] & ~at_or_above[i+1];
            end
        end
    endgenerate

    always_comb begin
        idx = '0;
        for (int i = 0; i < NPORT; i++) begin
            if (hit[i]) begin
                idx = IW'(i);
            end
        end
    end

endmodule

// File: rtl/dbd_fanout.sv
module dbd_fanout #(
    parameter int NPORT = 4,
    parameter int AW    = 32,
    parameter int DW    = 32,
    parameter int BW    = DW / 8
) (
    input  logic              stb,
    input  logic              we,
    input  logic [AW-1:0]     addr,
    input  logic [DW-1:0]     wdata,
    input  logic [BW-1:0]     sel,
    input  logic [NPORT-1:0]  hit,
    output logic [NPORT*AW-1:0] s_addr,
    output logic [NPORT*DW-1:0] s_wdata,
    output logic [NPORT*BW-1:0] s_sel,
    output logic [NPORT-1:0]  s_we,
    output logic [NPORT-1:0]  s_stb
);

    generate
        for (genvar i = 0; i < NPORT; i++) begin : g_port
            logic take;
            assign take                  = stb & hit[i];
            assign s_stb[i]              = take;
            assign s_we[i]               = take & we;
            assign s_addr[i*AW +: AW]    = take ? addr  : '0;
            assign s_wdata[i*DW +: DW]   = take ? wdata : '0;
            assign s_sel[i*BW +: BW]     = take ? sel   : '0;
        end
    endgenerate

endmodule

// File: rtl/dbd_return.sv
module dbd_return
    import dbd_pkg::*;
#(
    parameter int NPORT = 4,
    parameter int DW    = 32,
    parameter int IW    = 2
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                stb,
    input  logic                we,
    input  logic [IW-1:0]       idx,
    input  logic [NPORT*DW-1:0] s_rdata,
    input  logic [NPORT-1:0]    s_ready,
    output logic [DW-1:0]       rdata,
    output logic                ready
);

    ret_state_t    state;
    ret_state_t    state_nx;
    logic [IW-1:0] held_idx;
    logic          read_issue;
    logic [DW-1:0] rd_arr [NPORT];

    assign read_issue = stb & ~we;

    generate
        for (genvar i = 0; i < NPORT; i++) begin : g_unpack
            assign rd_arr[i] = s_rdata[i*DW +: DW];
        end
    endgenerate

    // state register and held port index
    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= RET_IDLE;
            held_idx <= '0;
        end else begin
            state <= state_nx;
            if (read_issue) begin
                held_idx <= idx;
            end
        end
    end

    // next state: READ_ISSUED / NO_READ
    always_comb begin
        state_nx = RET_IDLE;
        unique case (state)
            RET_IDLE: state_nx = read_issue ? RET_READ : RET_IDLE;
            RET_READ: state_nx = read_issue ? RET_READ : RET_IDLE;
            default:  state_nx = RET_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        rdata = '0;
        unique case (state)
            RET_IDLE: rdata = '0;
            RET_READ: rdata = rd_arr[held_idx];
            default:  rdata = '0;
        endcase
        ready = stb ? s_ready[idx] : 1'b1;
    end

endmodule

// File: rtl/dbd_decoder.sv
module dbd_decoder #(
    parameter int NPORT = 4,
    parameter int AW    = 32,
    parameter int DW    = 32,
    parameter logic [NPORT*AW-1:0] BASE_MAP =
        {32'hC000_0000, 32'h8000_0000, 32'h1000_0000, 32'h0000_0000}
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic [AW-1:0]             m_addr,
    input  logic [DW-1:0]             m_wdata,
    input  logic [DW/8-1:0]           m_sel,
    input  logic                      m_we,
    input  logic                      m_stb,
    output logic [DW-1:0]             m_rdata,
    output logic                      m_ready,
    output logic [NPORT*AW-1:0]       s_addr,
    output logic [NPORT*DW-1:0]       s_wdata,
    output logic [NPORT*(DW/8)-1:0]   s_sel,
    output logic [NPORT-1:0]          s_we,
    output logic [NPORT-1:0]          s_stb,
    input  logic [NPORT*DW-1:0]       s_rdata,
    input  logic [NPORT-1:0]          s_ready
);

    localparam int BW = DW / 8;
    localparam int IW = (NPORT < 2) ? 1 : $clog2(NPORT);

    logic [NPORT-1:0] hit;
    logic [IW-1:0]    idx;

    dbd_region_match #(
        .NPORT    (NPORT),
        .AW       (AW),
        .IW       (IW),
        .BASE_MAP (BASE_MAP)
    ) u_match (
        .addr (m_addr),
        .hit  (hit),
        .idx  (idx)
    );

    dbd_fanout #(
        .NPORT (NPORT),
        .AW    (AW),
        .DW    (DW),
        .BW    (BW)
    ) u_fanout (
        .stb     (m_stb),
        .we      (m_we),
        .addr    (m_addr),
        .wdata   (m_wdata),
        .sel     (m_sel),
        .hit     (hit),
        .s_addr  (s_addr),
        .s_wdata (s_wdata),
        .s_sel   (s_sel),
        .s_we    (s_we),
        .s_stb   (s_stb)
    );

    dbd_return #(
        .NPORT (NPORT),
        .DW    (DW),
        .IW    (IW)
    ) u_return (
        .clk     (clk),
        .rst     (rst),
        .stb     (m_stb),
        .we      (m_we),
        .idx     (idx),
        .s_rdata (s_rdata),
        .s_ready (s_ready),
        .rdata   (m_rdata),
        .ready   (m_ready)
    );

endmodule

// File: rtl/dbd_decoder_chk.sv
module dbd_decoder_chk #(
    parameter int NPORT = 4,
    parameter int AW    = 32,
    parameter int DW    = 32
) (
    input logic                    clk,
    input logic                    rst,
    input logic [AW-1:0]           m_addr,
    input logic                    m_we,
    input logic                    m_stb,
    input logic [DW-1:0]           m_rdata,
    input logic                    m_ready,
    input logic [NPORT*AW-1:0]     s_addr,
    input logic [NPORT-1:0]        s_we,
    input logic [NPORT-1:0]        s_stb,
    input logic [NPORT*DW-1:0]     s_rdata,
    input logic [NPORT-1:0]        s_ready
);

    function automatic logic [DW-1:0] pick_rd(input logic [NPORT-1:0] oh,
                                              input logic [NPORT*DW-1:0] flat);
        logic [DW-1:0] acc;
        acc = '0;
        for (int i = 0; i < NPORT; i++) begin
            if (oh[i]) acc = acc | flat[i*DW +: DW];
        end
        return acc;
    endfunction

    function automatic logic [AW-1:0] merge_addr(input logic [NPORT*AW-1:0] flat);
        logic [AW-1:0] acc;
        acc = '0;
        for (int i = 0; i < NPORT; i++) begin
            acc = acc | flat[i*AW +: AW];
        end
        return acc;
    endfunction

    assert_one_port_R4: assert property (@(posedge clk) disable iff (rst)
        m_stb |-> ($countones(s_stb) == 1));

    assert_idle_ports_R5: assert property (@(posedge clk) disable iff (rst)
        !m_stb |-> (s_stb == '0 && s_we == '0));

    assert_we_gated_R6: assert property (@(posedge clk) disable iff (rst)
        (m_stb && !m_we) |-> (s_we == '0));

    assert_addr_pass_R3: assert property (@(posedge clk) disable iff (rst)
        m_stb |-> (merge_addr(s_addr) == m_addr));

    assert_read_return_R7: assert property (@(posedge clk) disable iff (rst)
        (m_stb && !m_we) |=> (m_rdata == pick_rd($past(s_stb), s_rdata)));

    assert_rdata_quiet_R8: assert property (@(posedge clk) disable iff (rst)
        !(m_stb && !m_we) |=> (m_rdata == '0));

    assert_ready_path_R9: assert property (@(posedge clk) disable iff (rst)
        m_stb |-> (m_ready == |(s_stb & s_ready)));

    assert_ready_idle_R9: assert property (@(posedge clk) disable iff (rst)
        !m_stb |-> m_ready);

endmodule

bind dbd_decoder dbd_decoder_chk #(
    .NPORT (NPORT),
    .AW    (AW),
    .DW    (DW)
) u_chk (
    .clk     (clk),
    .rst     (rst),
    .m_addr  (m_addr),
    .m_we    (m_we),
    .m_stb   (m_stb),
    .m_rdata (m_rdata),
    .m_ready (m_ready),
    .s_addr  (s_addr),
    .s_we    (s_we),
    .s_stb   (s_stb),
    .s_rdata (s_rdata),
    .s_ready (s_ready)
);

// File: tb/dbd_decoder_test.sv
module dbd_decoder_test;

    logic         clk = 1'b0;
    logic         rst;
    logic [31:0]  m_addr;
    logic [31:0]  m_wdata;
    logic [3:0]   m_sel;
    logic         m_we;
    logic         m_stb;
    logic [31:0]  m_rdata;
    logic         m_ready;
    logic [127:0] s_addr;
    logic [127:0] s_wdata;
    logic [15:0]  s_sel;
    logic [3:0]   s_we;
    logic [3:0]   s_stb;
    logic [127:0] s_rdata;
    logic [3:0]   s_ready;

    int n_cmp = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #4 clk = ~clk;

    dbd_decoder uut (
        .clk     (clk),
        .rst     (rst),
        .m_addr  (m_addr),
        .m_wdata (m_wdata),
        .m_sel   (m_sel),
        .m_we    (m_we),
        .m_stb   (m_stb),
        .m_rdata (m_rdata),
        .m_ready (m_ready),
        .s_addr  (s_addr),
        .s_wdata (s_wdata),
        .s_sel   (s_sel),
        .s_we    (s_we),
        .s_stb   (s_stb),
        .s_rdata (s_rdata),
        .s_ready (s_ready)
    );

    function automatic logic [31:0] port_data(input int p);
        return (32'h1111_1111 * p) ^ 32'h0000_ABCD;
    endfunction

    function automatic int owner(input logic [31:0] a);
        if (a >= 32'hC000_0000) return 3;
        if (a >= 32'h8000_0000) return 2;
        if (a >= 32'h1000_0000) return 1;
        return 0;
    endfunction

    task automatic chk(input string req, input string what,
                       input logic [127:0] act, input logic [127:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic drive(input logic stb, input logic we, input logic [31:0] a,
                         input logic [31:0] wd, input logic [3:0] bs);
        @(negedge clk);
        m_stb = stb; m_we = we; m_addr = a; m_wdata = wd; m_sel = bs;
        #1;
    endtask

    task automatic t_reset;
        chk("R1", "stb", 128'(s_stb), 128'h0);
        chk("R1", "rdata", 128'(m_rdata), 128'h0);
        chk("R1", "ready", 128'(m_ready), 128'h1);
    endtask

    task automatic t_decode;
        logic [31:0] probes [8];
        probes = '{32'h0000_0000, 32'h0FFF_FFFF, 32'h1000_0000, 32'h7FFF_FFFF,
                   32'h8000_0000, 32'hBFFF_FFFF, 32'hC000_0000, 32'hFFFF_FFFF};
        for (int k = 0; k < 8; k++) begin
            int p;
            logic [127:0] mask;
            p    = owner(probes[k]);
            mask = 128'hFFFF_FFFF << (p * 32);
            drive(1'b1, 1'b0, probes[k], 32'h0, 4'b1001);
            chk("R2", "port strobe", 128'(s_stb), 128'(4'b1 << p));
            chk("R3", "addr at port", 128'(s_addr[p*32 +: 32]), 128'(probes[k]));
            chk("R3", "sel at port", 128'(s_sel[p*4 +: 4]), 128'(4'b1001));
            chk("R4", "other addr zero", s_addr & ~mask, 128'h0);
            chk("R4", "other sel zero", 128'(s_sel & ~(16'hF << (p * 4))), 128'h0);
        end
    endtask

    task automatic t_write;
        drive(1'b1, 1'b1, 32'h8000_0040, 32'hCAFE_F00D, 4'b0110);
        chk("R6", "we only at port 2", 128'(s_we), 128'(4'b0100));
        chk("R3", "wdata at port 2", 128'(s_wdata[64 +: 32]), 128'(32'hCAFE_F00D));
        chk("R4", "wdata elsewhere", s_wdata & ~(128'hFFFF_FFFF << 64), 128'h0);
        drive(1'b1, 1'b0, 32'h8000_0040, 32'hCAFE_F00D, 4'b1111);
        chk("R6", "no we on read", 128'(s_we), 128'h0);
        chk("R8", "rdata after write", 128'(m_rdata), 128'h0);
    endtask

    task automatic t_readret;
        drive(1'b1, 1'b0, 32'h1234_0000, 32'h0, 4'b1111);
        drive(1'b1, 1'b0, 32'hD000_0000, 32'h0, 4'b1111);
        chk("R7", "rdata from port 1", 128'(m_rdata), 128'(port_data(1)));
        drive(1'b1, 1'b1, 32'h0000_0100, 32'h5, 4'b0001);
        chk("R7", "rdata from port 3", 128'(m_rdata), 128'(port_data(3)));
        drive(1'b0, 1'b0, 32'h0, 32'h0, 4'b0000);
        chk("R8", "rdata after write", 128'(m_rdata), 128'h0);
        drive(1'b0, 1'b0, 32'h0, 32'h0, 4'b0000);
        chk("R8", "rdata after idle", 128'(m_rdata), 128'h0);
    endtask

    task automatic t_idle;
        drive(1'b0, 1'b1, 32'h9000_0000, 32'hFFFF_FFFF, 4'b1111);
        chk("R5", "stb idle", 128'(s_stb), 128'h0);
        chk("R5", "we idle", 128'(s_we), 128'h0);
        chk("R5", "addr idle", s_addr, 128'h0);
        chk("R5", "wdata idle", s_wdata, 128'h0);
        chk("R9", "ready idle", 128'(m_ready), 128'h1);
    endtask

    task automatic t_ready;
        s_ready = 4'b1011;
        drive(1'b1, 1'b0, 32'h8000_0000, 32'h0, 4'b1111);
        chk("R9", "port2 not ready", 128'(m_ready), 128'h0);
        drive(1'b1, 1'b0, 32'h0000_0010, 32'h0, 4'b1111);
        chk("R9", "port0 ready", 128'(m_ready), 128'h1);
        s_ready = 4'b0100;
        drive(1'b1, 1'b1, 32'h8000_0004, 32'h0, 4'b1111);
        chk("R9", "port2 ready", 128'(m_ready), 128'h1);
        drive(1'b1, 1'b1, 32'hF000_0004, 32'h0, 4'b1111);
        chk("R9", "port3 not ready", 128'(m_ready), 128'h0);
        s_ready = 4'b1111;
        drive(1'b0, 1'b0, 32'h0, 32'h0, 4'b0000);
    endtask

    task automatic summary;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    initial begin
        #800000;
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            summary();
        end
    end

    initial begin
        rst = 1'b1;
        m_stb = 1'b0; m_we = 1'b0; m_addr = '0; m_wdata = '0; m_sel = '0;
        s_ready = 4'b1111;
        for (int p = 0; p < 4; p++) s_rdata[p*32 +: 32] = port_data(p);
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        #1;
        t_reset();
        t_decode();
        t_write();
        t_readret();
        t_idle();
        t_ready();
        done = 1'b1;
        summary();
    end

endmodule